// File: doc/BRIEF.md
# Pipelined GF(2^m) Exponentiator over an All-One-Polynomial Field

The block raises a field element to a power in GF(2^M), where the field is built on the all-one polynomial x^M + x^(M-1) + ... + x + 1. This polynomial is irreducible only when M+1 is prime and 2 generates the multiplicative group modulo M+1. The default is M = 10. A base `in_base` and an exponent `in_exp` enter together, and the result `in_base^in_exp` leaves the pipeline a fixed number of cycles later. Once the pipeline is full, one result is produced on every cycle.

Inside, values are held in an (M+1)-bit redundant form: the ring GF(2)[x]/(x^(M+1)-1). In that form, squaring is only a reordering of wires, so every power base^(2^i) is available in the same cycle. A register stage then replaces each power whose exponent bit is clear with the unit element. Positions beyond M are padded with the unit, which brings the leaf count up to a power of two. A balanced tree of pipelined multipliers, with ceil(log2 M) levels, multiplies the leaves together. Each multiplier adds one partial product per stage, so every stage is a single AND feeding a single XOR. The last stage of each multiplier folds the result back into M-bit canonical form.

Both ends of the block use valid/ready handshakes. The output may be back-pressured: while `out_valid` is high and `out_ready` is low, the whole pipeline freezes and `in_ready` drops. An input is taken only on a clock edge where both `in_valid` and `in_ready` are high. A result is handed off on a clock edge where both `out_valid` and `out_ready` are high.

Top module: `aop_exp_tree`

## Requirements
- R1: Whenever `out_valid` is high, `out_data` equals base^exp in GF(2^M) modulo the all-one polynomial. Bit i of every field value is the coefficient of x^i, and the value is fully reduced, so it has degree below M.
- R2: An accepted input with exp = 0 yields the unit element, which is the value 1, for any base, including base 0.
- R3: An accepted input with base = 0 and exp not 0 yields 0.
- R4: With `out_ready` held high, a result appears with `out_valid` high right after the LAT-th rising edge, counting the edge that accepted the input as the first. LAT = (M+2)*ceil(log2 M) + 1, which is 49 for M = 10.
- R5: With `out_ready` high, one input is accepted on every cycle. Results come out in the order the inputs were accepted, with no loss and no duplication.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values, no internal stage advances, and `in_ready` is low. Otherwise `in_ready` is high.
- R7: A rising edge where `in_valid` is high and `in_ready` is low does not accept the input, and that input never produces a result.
- R8: While reset is asserted and right after it, `out_valid` is low and `in_ready` is high.
- R9: exp = 1 returns the base unchanged. An exponent with only bit i set returns base^(2^i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pair is offered |
| in_ready | output | 1 | Block can take an input on this edge |
| in_base | input | M | Field element to raise |
| in_exp | input | M | Exponent, unsigned |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_data | output | M | Reduced field result |

## Verification
A stall and a new acceptance interact within one cycle. On the same edge that `out_ready` falls, a fresh `in_valid` may be offered, and the offer must be dropped while the held result stays frozen. The bench provokes this by randomising `out_ready` and `in_valid` independently and by inserting long stall bursts in the middle of a dense input stream. A behavioural slot model, updated on every edge, decides which inputs were accepted and when each result is due. Each clock, `out_valid`, `in_ready` and `out_data` are compared against a square-and-multiply reference.

// File: rtl/aop_exp_pkg.sv
package aop_exp_pkg;

  // Index of the source coefficient for bit k of a^(2^i) in the ring of
  // size w (w odd): the inverse of 2 modulo w, applied i times.
  function automatic int sq_src(int k, int i, int w);
    int idx;
    idx = k;
    for (int n = 0; n < i; n++) idx = (idx * ((w + 1) / 2)) % w;
    return idx;
  endfunction

  // Number of tree levels needed for a leaf count.
  function automatic int tree_depth(int leaves);
    int d;
    d = 0;
    while ((1 << d) < leaves) d++;
    return d;
  endfunction

endpackage

// File: rtl/aop_square_bank.sv
module aop_square_bank #(
  parameter int M = 10
) (
  input  logic [M-1:0]          base,
  output logic [M-1:0][M:0]     powers
);
  import aop_exp_pkg::*;
  localparam int W = M + 1;

  logic [W-1:0] base_ext;
  assign base_ext = {1'b0, base};

  // Every power base^(2^i) is a fixed permutation of the extended base.
  for (genvar i = 0; i < M; i++) begin : g_pow
    for (genvar k = 0; k < W; k++) begin : g_bit
      localparam int SRC = sq_src(k, i, W);
      assign powers[i][k] = base_ext[SRC];
    end
  end
endmodule

// File: rtl/aop_leaf_select.sv
module aop_leaf_select #(
  parameter int M  = 10,
  parameter int NL = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [M-1:0][M:0]      powers,
  input  logic [M-1:0]           exp_bits,
  output logic [NL-1:0][M:0]     leaves
);
  localparam int W = M + 1;
  localparam logic [W-1:0] UNIT = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leaves <= {NL{UNIT}};
    end else if (en) begin
      for (int i = 0; i < NL; i++) begin
        if (i < M && exp_bits[i % M]) leaves[i] <= powers[i % M];
        else                          leaves[i] <= UNIT;
      end
    end
  end

  // R2: a zero exponent leaves only unit elements in the tree inputs
  a_r2_unit_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (en && exp_bits == '0) |=> (leaves == {NL{UNIT}}));
endmodule

// File: rtl/aop_mul_pipe.sv
module aop_mul_pipe #(
  parameter int M = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [M:0]  op_a,
  input  logic [M:0]  op_b,
  output logic [M:0]  prod
);
  localparam int W = M + 1;
  localparam int ACC = M + 1;   // accumulation stages, one per coefficient of op_b

  logic [W-1:0] a_pipe [1:M];
  logic [W-1:0] b_pipe [1:M];
  logic [W-1:0] c_pipe [1:ACC];

  function automatic logic [W-1:0] rot1(input logic [W-1:0] x);
    return {x[W-2:0], x[W-1]};
  endfunction

  for (genvar k = 1; k <= ACC; k++) begin : g_st
    if (k == 1) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          a_pipe[1] <= '0;
          b_pipe[1] <= '0;
          c_pipe[1] <= '0;
        end else if (en) begin
          a_pipe[1] <= rot1(op_a);
          b_pipe[1] <= op_b >> 1;
          c_pipe[1] <= op_a & {W{op_b[0]}};
        end
      end
    end else if (k <= M) begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          a_pipe[k] <= '0;
          b_pipe[k] <= '0;
          c_pipe[k] <= '0;
        end else if (en) begin
          a_pipe[k] <= rot1(a_pipe[k-1]);
          b_pipe[k] <= b_pipe[k-1] >> 1;
          c_pipe[k] <= c_pipe[k-1] ^ (a_pipe[k-1] & {W{b_pipe[k-1][0]}});
        end
      end
    end else begin : g_last
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_pipe[k] <= '0;
        else if (en) c_pipe[k] <= c_pipe[k-1] ^ (a_pipe[k-1] & {W{b_pipe[k-1][0]}});
      end
    end
  end

  // Fold the ring value into the field: adding the all-one polynomial
  // clears the top coefficient.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod <= '0;
    else if (en) begin
      if (c_pipe[ACC][W-1]) prod <= {1'b0, ~c_pipe[ACC][W-2:0]};
      else                  prod <= {1'b0,  c_pipe[ACC][W-2:0]};
    end
  end

  // R6: a frozen pipeline keeps its product
  a_r6_freeze_product: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(prod));
endmodule

// File: rtl/aop_mul_tree.sv
module aop_mul_tree #(
  parameter int M  = 10,
  parameter int D  = 4,
  parameter int NL = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [NL-1:0][M:0]   leaves,
  output logic [M:0]           root
);
  localparam int W = M + 1;

  for (genvar l = 0; l <= D; l++) begin : g_lv
    localparam int CNT = NL >> l;
    logic [CNT-1:0][W-1:0] nd;
    if (l == 0) begin : g_leaf
      assign nd = leaves;
    end else begin : g_mul
      for (genvar i = 0; i < CNT; i++) begin : g_node
        aop_mul_pipe #(.M(M)) u_mul (
          .clk   (clk),
          .rst_n (rst_n),
          .en    (en),
          .op_a  (g_lv[l-1].nd[2*i]),
          .op_b  (g_lv[l-1].nd[2*i+1]),
          .prod  (nd[i])
        );
      end
    end
  end

  assign root = g_lv[D].nd[0];
endmodule

// File: rtl/aop_exp_tree.sv
module aop_exp_tree #(
  parameter int M = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [M-1:0]  in_base,
  input  logic [M-1:0]  in_exp,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [M-1:0]  out_data
);
  import aop_exp_pkg::*;
  localparam int W   = M + 1;
  localparam int D   = tree_depth(M);
  localparam int NL  = 1 << D;
  localparam int LAT = (M + 2) * D + 1;

  logic                  adv;
  logic [M-1:0][W-1:0]   powers;
  logic [NL-1:0][W-1:0]  leaves;
  logic [W-1:0]          root;
  logic [LAT-1:0]        vpipe;

  assign adv      = out_ready | ~out_valid;
  assign in_ready = adv;

  aop_square_bank #(.M(M)) u_sq (
    .base   (in_base),
    .powers (powers)
  );

  aop_leaf_select #(.M(M), .NL(NL)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (adv),
    .powers   (powers),
    .exp_bits (in_exp),
    .leaves   (leaves)
  );

  aop_mul_tree #(.M(M), .D(D), .NL(NL)) u_tree (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (adv),
    .leaves (leaves),
    .root   (root)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vpipe <= '0;
    else if (adv) vpipe <= {vpipe[LAT-2:0], in_valid};
  end

  assign out_valid = vpipe[LAT-1];
  assign out_data  = root[M-1:0];

  // R6: a refused result stays put
  a_r6_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R1: the tree root is always in reduced form when presented
  a_r1_root_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !root[W-1]);
endmodule

// File: tb/sim_aop_exp_tree.sv
`timescale 1ns/1ps
module sim_aop_exp_tree;
  localparam int M   = 10;
  localparam int D   = 4;
  localparam int LAT = (M + 2) * D + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [M-1:0] in_base = '0;
  logic [M-1:0] in_exp = '0;
  logic in_ready, out_valid;
  logic [M-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit live = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  aop_exp_tree #(.M(M)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_exp(in_exp), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  // Reference field arithmetic: schoolbook multiply, then reduce modulo
  // the all-one polynomial of degree M.
  function automatic logic [M-1:0] rmul(logic [M-1:0] a, logic [M-1:0] b);
    logic [2*M-1:0] r;
    logic [2*M-1:0] poly;
    r = '0;
    poly = (2*M)'((1 << (M + 1)) - 1);
    for (int i = 0; i < M; i++) if (b[i]) r = r ^ ((2*M)'(a) << i);
    for (int d = 2*M-2; d >= M; d--) if (r[d]) r = r ^ (poly << (d - M));
    return r[M-1:0];
  endfunction

  function automatic logic [M-1:0] rpow(logic [M-1:0] a, logic [M-1:0] e);
    logic [M-1:0] res, sq;
    res = M'(1);
    sq = a;
    for (int i = 0; i < M; i++) begin
      if (e[i]) res = rmul(res, sq);
      sq = rmul(sq, sq);
    end
    return res;
  endfunction

  function automatic int tag_of(logic [M-1:0] a, logic [M-1:0] e);
    if (e == '0) return 2;                 // R2
    if (a == '0) return 3;                 // R3
    if ($countones(e) == 1) return 9;      // R9
    return 1;                              // R1
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Slot model: one entry per register stage of the pipeline.
  bit           mv [0:LAT-1];
  logic [M-1:0] md [0:LAT-1];
  int           mt [0:LAT-1];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin mv[i] = 0; md[i] = '0; mt[i] = 0; end
    end else begin
      if (out_ready || !mv[LAT-1]) begin
        for (int i = LAT-1; i > 0; i--) begin
          mv[i] = mv[i-1]; md[i] = md[i-1]; mt[i] = mt[i-1];
        end
        mv[0] = in_valid;                 // refused offers never enter (R7)
        md[0] = rpow(in_base, in_exp);
        mt[0] = tag_of(in_base, in_exp);
      end
    end
  end

  // Per-clock comparison, away from the rising edge.
  always @(negedge clk) begin
    if (live && rst_n) begin
      chk(out_valid == mv[LAT-1], "R5 out_valid", int'(out_valid), int'(mv[LAT-1]));
      chk(in_ready == (out_ready || !mv[LAT-1]), "R6 R7 in_ready",
          int'(in_ready), int'(out_ready || !mv[LAT-1]));
      if (mv[LAT-1])
        chk(out_data == md[LAT-1], $sformatf("R%0d out_data", mt[LAT-1]),
            int'(out_data), int'(md[LAT-1]));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic push(logic [M-1:0] a, logic [M-1:0] e);
    @(negedge clk); #1;
    in_valid = 1'b1; in_base = a; in_exp = e;
  endtask

  initial begin
    // R8: reset state
    #12;
    chk(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8 in_ready in reset", int'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8 in_ready after reset", int'(in_ready), 1);
    live = 1;

    // R4: latency of a lone item, R1 value
    begin
      int cnt;
      push(10'h2B3, 10'h1F5);
      @(negedge clk); cnt = 1; #1 in_valid = 1'b0;
      while (!out_valid && cnt < 200) begin @(negedge clk); cnt++; end
      chk(cnt == LAT, "R4 latency", cnt, LAT);
      chk(out_data == rpow(10'h2B3, 10'h1F5), "R1 lone result", int'(out_data),
          int'(rpow(10'h2B3, 10'h1F5)));
    end
    repeat (4) @(negedge clk);

    // Directed corners in a back-to-back stream (R2 R3 R9 R5)
    push(10'h155, 10'h000);   // R2
    push(10'h000, 10'h000);   // R2
    push(10'h000, 10'h3FF);   // R3
    push(10'h000, 10'h001);   // R3
    push(10'h2C7, 10'h001);   // R9
    for (int i = 0; i < M; i++) push(10'h1A9, M'(1) << i);  // R9
    push(10'h3FF, 10'h3FF);   // R1
    push(10'h001, 10'h2AA);   // R1
    push(10'h3FF, 10'h002);   // R9
    for (int i = 0; i < 40; i++) push(M'($urandom), M'($urandom));
    @(negedge clk); #1 in_valid = 1'b0;
    repeat (LAT + 4) @(negedge clk);

    // Back-pressure with simultaneous offers (R6 R7)
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk); #1;
      in_valid = ($urandom % 4) != 0;
      in_base  = (($urandom % 8) == 0) ? '0 : M'($urandom);
      in_exp   = (($urandom % 8) == 0) ? '0 : M'($urandom);
      if ((n % 500) > 440) out_ready = 1'b0;
      else out_ready = ($urandom % 3) != 0;
    end
    @(negedge clk); #1 in_valid = 1'b0; out_ready = 1'b1;
    repeat (LAT + 4) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule